// File: doc/BRIEF.md
# GPIO Interrupt and Line-Mode Controller

This block owns four general-purpose pins, a level-change interrupt for the host, and the two control outputs that tell a line-side isolation device which hook state to take. The host programs it through a small register port. Each pin can be an input or an output. As an output it drives either a static level or, on two of the pins, a clock derived from the internal modulation carrier F0. Every pin has an interrupt mask bit, and the ring-detect level has one as well. A level change on any unmasked input pulls the active-low interrupt line down. The line goes high again only when the host reads the status register.

The line state (on-hook, off-hook, caller-ID, or a spare fourth code) comes from one of two places, chosen by a hardware-mode pin. It is either taken from two of the pins or from two register bits. The state is turned into fixed waveforms on the two isolation control outputs: both high, F0 in antiphase, or F0 on the first output with the second held high. The carrier is generated internally from the core clock.

Top module: `gpio_line_ctrl`

## Requirements
- R1: After reset all four pins are inputs (`gpio_oe` = 0) and every mask bit is 0, which means masked. `irq_n` is 1, both isolation outputs are 1, and the configuration register reads 0.
- R2: Configuration register (address 1) layout: bits 3:0 set the pin directions (1 = drive), bits 7:4 hold the pin masks, and bit 8 holds the ring mask. A mask bit of 1 means unmasked. In the output register (address 2), bits 3:0 give the static pin levels. `gpio_oe` follows the direction bits, and `gpio_out` carries the static levels on any pin that has no clock selected.
- R3: Output register bit 6 replaces pin 0's static level with a carrier-derived clock. Bits 5:4 pick the clock: 0 = F0, 1 = F0/2, 2 = F0/4, 3 = F0/8. F0 has a period of 2·CAR_HALF core clocks.
- R4: Output register bit 7 replaces pin 3's static level with F0.
- R5: A level change on a pin whose direction is input and whose mask bit is 1 drives `irq_n` low. The pin passes through two synchronising flops and one edge register, so `irq_n` falls on the third rising edge after the change. A masked pin never affects `irq_n`, and neither does a pin set to drive.
- R6: When the ring mask is 1, a change of `ring_in` drives `irq_n` low on the next rising edge.
- R7: A read of address 2 returns `irq_n` to 1 on that edge. A read of any other address leaves `irq_n` unchanged. If a change event occurs in the same cycle as the read, `irq_n` stays low.
- R8: A read of address 2 returns the synchronised pin levels in bits 3:0 and the registered ring level in bit 5. All other bits read 0.
- R9: With `hw_mode` = 1, synchronised pin 1 is the caller-ID request (CL) and synchronised pin 2 is the off-hook request (OH). With `hw_mode` = 0, the line register (address 3) supplies them: bit 1 = CL, bit 0 = OH.
- R10: The pair {CL,OH} selects the isolation outputs, which are registered:
  - 00 (on-hook): both outputs are 1.
  - 01 (off-hook): the outputs carry F0 in opposite phase.
  - 10 (caller-ID): `iso_a` carries F0 and `iso_b` is held at 1.
  - 11 (spare): both outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 clears the interrupt) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for `reg_addr` |
| gpio_in | input | 4 | Pin levels seen at the pads |
| gpio_out | output | 4 | Pin drive values |
| gpio_oe | output | 4 | Pin drive enables |
| ring_in | input | 1 | Ring-detect level from the detector |
| hw_mode | input | 1 | 1: line mode taken from pins 1 and 2; 0: taken from the line register |
| irq_n | output | 1 | Active-low interrupt |
| iso_a | output | 1 | First isolation control output |
| iso_b | output | 1 | Second isolation control output |

## Verification
The bench measures interrupt latency cycle by cycle. A synchroniser one stage short would drop `irq_n` a cycle early, and a missing stage would show up the same way. It drives changes on masked pins and on output-direction pins, and reads registers other than the status register. A design that ignored the mask or the direction would then assert a false interrupt, and one that cleared on any read would lose a pending one. A change is also forced into the very cycle of a status read, where a clear-priority design would drop the event. The divided clocks and the isolation waveforms are checked by counting transitions over windows that hold a whole number of periods, so a wrong divider tap, a wrong phase relation or a wrong mode source gives a count that differs from the expected one.

// File: rtl/gpl_pkg.sv
package gpl_pkg;

  localparam int NPIN = 4;
  localparam int DW   = 9;
  localparam int AW   = 2;

  localparam logic [AW-1:0] ADDR_CFG  = 2'd1;
  localparam logic [AW-1:0] ADDR_STAT = 2'd2;
  localparam logic [AW-1:0] ADDR_LINE = 2'd3;

  // configuration register fields
  localparam int CFG_DIR_LO  = 0;
  localparam int CFG_MSK_LO  = 4;
  localparam int CFG_RMSK    = 8;
  // output register fields
  localparam int OUT_VAL_LO  = 0;
  localparam int OUT_SEL_LO  = 4;
  localparam int OUT_G0_CLK  = 6;
  localparam int OUT_G3_CLK  = 7;
  // status read field
  localparam int STAT_RING   = 5;
  // line register fields
  localparam int LINE_OH     = 0;
  localparam int LINE_CL     = 1;

  typedef enum logic [1:0] {
    LM_ONHOOK  = 2'b00,
    LM_OFFHOOK = 2'b01,
    LM_CID     = 2'b10,
    LM_SPARE   = 2'b11
  } line_mode_e;

endpackage

// File: rtl/gpl_carrier.sv
module gpl_carrier #(
  parameter int CAR_HALF = 2,
  parameter int PH_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase_o,
  output logic            tick_o
);

  localparam int CW = (CAR_HALF > 1) ? $clog2(CAR_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CAR_HALF - 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            tick;

  always_comb begin
    tick  = (cnt_q == CNT_LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    ph_d  = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (tick) ph_q <= ph_d;
    end
  end

  assign phase_o = ph_q;
  assign tick_o  = tick;

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_o == $past(phase_o) + 1'b1));
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_o));

endmodule

// File: rtl/gpl_sync.sv
module gpl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= '0;
    else        st_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= '0;
      else        st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/gpl_regs.sv
module gpl_regs
  import gpl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pin_sync_i,
  input  logic            ring_i,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] val_o,
  output logic [1:0]      g0_sel_o,
  output logic            g0_clk_o,
  output logic            g3_clk_o,
  output logic            cl_o,
  output logic            oh_o,
  output logic            irq_n_o
);

  logic [NPIN-1:0] dir_q, msk_q, val_q, pin_q;
  logic            rmsk_q, g0_clk_q, g3_clk_q, cl_q, oh_q, ring_q;
  logic [1:0]      g0_sel_q;
  logic            pend_q, pend_d;
  logic            cfg_en, out_en, line_en, stat_rd;
  logic [NPIN-1:0] pin_evt;
  logic            ring_evt, any_evt;

  // clock enables
  always_comb begin
    cfg_en  = wr_i && (addr_i == ADDR_CFG);
    out_en  = wr_i && (addr_i == ADDR_STAT);
    line_en = wr_i && (addr_i == ADDR_LINE);
    stat_rd = rd_i && (addr_i == ADDR_STAT);
  end

  // change detection and interrupt next state
  always_comb begin
    pin_evt  = (pin_sync_i ^ pin_q) & ~dir_q & msk_q;
    ring_evt = (ring_i ^ ring_q) & rmsk_q;
    any_evt  = (|pin_evt) | ring_evt;
    if (any_evt)      pend_d = 1'b1;
    else if (stat_rd) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      msk_q    <= '0;
      rmsk_q   <= 1'b0;
      val_q    <= '0;
      g0_sel_q <= '0;
      g0_clk_q <= 1'b0;
      g3_clk_q <= 1'b0;
      cl_q     <= 1'b0;
      oh_q     <= 1'b0;
      pin_q    <= '0;
      ring_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (cfg_en) begin
        dir_q  <= wdata_i[CFG_DIR_LO +: NPIN];
        msk_q  <= wdata_i[CFG_MSK_LO +: NPIN];
        rmsk_q <= wdata_i[CFG_RMSK];
      end
      if (out_en) begin
        val_q    <= wdata_i[OUT_VAL_LO +: NPIN];
        g0_sel_q <= wdata_i[OUT_SEL_LO +: 2];
        g0_clk_q <= wdata_i[OUT_G0_CLK];
        g3_clk_q <= wdata_i[OUT_G3_CLK];
      end
      if (line_en) begin
        oh_q <= wdata_i[LINE_OH];
        cl_q <= wdata_i[LINE_CL];
      end
      pin_q  <= pin_sync_i;
      ring_q <= ring_i;
      pend_q <= pend_d;
    end
  end

  // read data
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG: begin
        rdata_o[CFG_DIR_LO +: NPIN] = dir_q;
        rdata_o[CFG_MSK_LO +: NPIN] = msk_q;
        rdata_o[CFG_RMSK]           = rmsk_q;
      end
      ADDR_STAT: begin
        rdata_o[NPIN-1:0] = pin_q;
        rdata_o[STAT_RING] = ring_q;
      end
      ADDR_LINE: begin
        rdata_o[LINE_OH] = oh_q;
        rdata_o[LINE_CL] = cl_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign dir_o    = dir_q;
  assign val_o    = val_q;
  assign g0_sel_o = g0_sel_q;
  assign g0_clk_o = g0_clk_q;
  assign g3_clk_o = g3_clk_q;
  assign cl_o     = cl_q;
  assign oh_o     = oh_q;
  assign irq_n_o  = ~pend_q;

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past(any_evt));
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !any_evt) |=> irq_n_o);
  assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> !irq_n_o);

endmodule

// File: rtl/gpl_line.sv
module gpl_line
  import gpl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_mode_i,
  input  logic pin_cl_i,
  input  logic pin_oh_i,
  input  logic reg_cl_i,
  input  logic reg_oh_i,
  input  logic f0_i,
  output logic iso_a_o,
  output logic iso_b_o
);

  line_mode_e mode;
  logic       a_q, b_q, a_d, b_d;

  always_comb begin
    if (hw_mode_i) mode = line_mode_e'({pin_cl_i, pin_oh_i});
    else           mode = line_mode_e'({reg_cl_i, reg_oh_i});
  end

  always_comb begin
    unique case (mode)
      LM_OFFHOOK: begin a_d = f0_i;  b_d = ~f0_i; end
      LM_CID:     begin a_d = f0_i;  b_d = 1'b1;  end
      default:    begin a_d = 1'b1;  b_d = 1'b1;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign iso_a_o = a_q;
  assign iso_b_o = b_q;

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_ONHOOK || mode == LM_SPARE) |=> (iso_a_o && iso_b_o));
  assert_antiphase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_OFFHOOK) |=> (iso_a_o != iso_b_o));
  assert_cid_b_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_CID) |=> iso_b_o);

endmodule

// File: rtl/gpio_line_ctrl.sv
module gpio_line_ctrl
  import gpl_pkg::*;
#(
  parameter int CAR_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] gpio_in,
  output logic [NPIN-1:0] gpio_out,
  output logic [NPIN-1:0] gpio_oe,
  input  logic            ring_in,
  input  logic            hw_mode,
  output logic            irq_n,
  output logic            iso_a,
  output logic            iso_b
);

  localparam int PH_W = 4;

  logic [1:0]      rst_q;
  logic            rst_s_n;
  logic [PH_W-1:0] phase;
  logic            tick;
  logic [NPIN-1:0] pin_sync, dir, val;
  logic [1:0]      g0_sel;
  logic            g0_clk, g3_clk, cl_bit, oh_bit;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  gpl_carrier #(.CAR_HALF(CAR_HALF), .PH_W(PH_W)) u_car (
    .clk(clk), .rst_n(rst_s_n), .phase_o(phase), .tick_o(tick)
  );

  gpl_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d_i(gpio_in), .q_o(pin_sync)
  );

  gpl_regs u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .pin_sync_i(pin_sync), .ring_i(ring_in),
    .dir_o(dir), .val_o(val), .g0_sel_o(g0_sel),
    .g0_clk_o(g0_clk), .g3_clk_o(g3_clk),
    .cl_o(cl_bit), .oh_o(oh_bit), .irq_n_o(irq_n)
  );

  gpl_line u_line (
    .clk(clk), .rst_n(rst_s_n), .hw_mode_i(hw_mode),
    .pin_cl_i(pin_sync[1]), .pin_oh_i(pin_sync[2]),
    .reg_cl_i(cl_bit), .reg_oh_i(oh_bit), .f0_i(phase[0]),
    .iso_a_o(iso_a), .iso_b_o(iso_b)
  );

  // pin drive: pin 0 and pin 3 may carry carrier clocks
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    if (p == 0) begin : g_div
      assign gpio_out[p] = g0_clk ? phase[g0_sel] : val[p];
    end else if (p == NPIN-1) begin : g_f0
      assign gpio_out[p] = g3_clk ? phase[0] : val[p];
    end else begin : g_static
      assign gpio_out[p] = val[p];
    end
  end

  assign gpio_oe = dir;

  assert_oe_reset_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (gpio_oe == '0 && irq_n));
  assert_static_out_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!g0_clk && !g3_clk && !tick) |=> $stable(gpio_out) || !$stable(val));

endmodule

// File: tb/gpio_line_ctrl_tb.sv
module gpio_line_ctrl_tb;

  localparam int CH = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [8:0] reg_wdata, reg_rdata;
  logic [3:0] gpio_in, gpio_out, gpio_oe;
  logic       ring_in, hw_mode, irq_n, iso_a, iso_b;

  always #10 clk = ~clk;

  gpio_line_ctrl #(.CAR_HALF(CH), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .ring_in(ring_in), .hw_mode(hw_mode), .irq_n(irq_n),
    .iso_a(iso_a), .iso_b(iso_b)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t       sb[$];
  int          pending = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] meas;
  logic        done = 1'b0;

  // driver side: push an expectation, let the monitor consume it
  task automatic expect_val(input string req, input int sel, input logic [15:0] exp);
    item_t it;
    #1;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  // monitor: pops and compares against the design outputs
  initial begin
    forever begin
      item_t       it;
      logic [15:0] act;
      wait (pending > 0);
      it = sb[0];
      case (it.sel)
        0: act = {7'b0, reg_rdata};
        1: act = {15'b0, irq_n};
        2: act = {12'b0, gpio_oe};
        3: act = {12'b0, gpio_out};
        4: act = {14'b0, iso_a, iso_b};
        default: act = meas;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
      end
      sb.delete(0);
      pending--;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input string req, input logic [8:0] exp);
    reg_addr = a; reg_rd = 1'b1;
    expect_val(req, 0, {7'b0, exp});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // transitions of one output over n intervals; which: 0 pin0, 1 pin3, 2 iso_a
  task automatic count_tog(input int which, input int n, output int tog);
    logic prev, cur;
    tog = 0;
    @(negedge clk);
    prev = (which == 0) ? gpio_out[0] : (which == 1) ? gpio_out[3] : iso_a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = (which == 0) ? gpio_out[0] : (which == 1) ? gpio_out[3] : iso_a;
      if (cur != prev) tog++;
      prev = cur;
    end
  endtask

  // iso window: toggles of iso_a, samples with iso_a==iso_b, samples with iso_b low
  task automatic iso_window(output int tog, output int same, output int blow);
    logic prev;
    tog = 0; same = 0; blow = 0;
    @(negedge clk);
    prev = iso_a;
    if (iso_a == iso_b) same++;
    if (!iso_b) blow++;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (iso_a != prev) tog++;
      prev = iso_a;
      if (iso_a == iso_b) same++;
      if (!iso_b) blow++;
    end
  endtask

  task automatic chk_offhook(input string req);
    int t, s, b;
    iso_window(t, s, b);
    meas = 16'(t); expect_val({req, " offhook toggles"}, 5, 16'd8);
    meas = 16'(s); expect_val({req, " offhook antiphase"}, 5, 16'd0);
  endtask

  task automatic chk_cid(input string req);
    int t, s, b;
    iso_window(t, s, b);
    meas = 16'(t); expect_val({req, " cid toggles"}, 5, 16'd8);
    meas = 16'(b); expect_val({req, " cid b high"}, 5, 16'd0);
  endtask

  task automatic chk_idle(input string req);
    int t, s, b;
    iso_window(t, s, b);
    meas = 16'(t + b); expect_val({req, " idle steady high"}, 5, 16'd0);
    expect_val({req, " idle level"}, 4, 16'h3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] gin;
    int         tg;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    gin = 4'b0000; gpio_in = gin; ring_in = 1'b0; hw_mode = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    expect_val("R1 irq idle", 1, 16'h1);
    expect_val("R1 all inputs", 2, 16'h0);
    expect_val("R1 iso high", 4, 16'h3);
    rd_chk(2'd1, "R1 cfg clear", 9'h000);

    // R2 direction and static value
    wr(2'd1, 9'h009);
    expect_val("R2 oe follows dir", 2, 16'h9);
    wr(2'd2, 9'h009);
    expect_val("R2 static out", 3, 16'h9);

    // R5 masked pin change: no interrupt
    gin[1] = 1'b1; gpio_in = gin;
    cyc(5);
    expect_val("R5 masked pin ignored", 1, 16'h1);

    // R5 unmasked pin change: latency of three edges
    wr(2'd1, 9'h029);
    cyc(2);
    gin[1] = 1'b0; gpio_in = gin;
    cyc(2);
    expect_val("R5 irq not yet", 1, 16'h1);
    cyc(1);
    expect_val("R5 irq asserted", 1, 16'h0);

    // R8 status content, R7 clear on status read
    rd_chk(2'd2, "R8 status pins", {3'b0, 1'b0, 1'b0, gin});
    expect_val("R7 cleared by status read", 1, 16'h1);

    // R7 read of another address keeps it pending
    gin[1] = 1'b1; gpio_in = gin;
    cyc(4);
    expect_val("R5 second event", 1, 16'h0);
    rd_chk(2'd1, "R2 cfg readback", 9'h029);
    expect_val("R7 other read no clear", 1, 16'h0);
    rd_chk(2'd2, "R8 status pins again", {5'b0, gin});
    expect_val("R7 clear again", 1, 16'h1);

    // R5 pin set to drive is ignored even when unmasked
    wr(2'd1, 9'h039);
    gin[0] = 1'b1; gpio_in = gin;
    cyc(5);
    expect_val("R5 output pin ignored", 1, 16'h1);

    // R6 ring masked, then unmasked
    ring_in = 1'b1;
    cyc(3);
    expect_val("R6 masked ring ignored", 1, 16'h1);
    rd_chk(2'd2, "R8 ring bit", {3'b0, 1'b1, 1'b0, gin});
    wr(2'd1, 9'h139);
    ring_in = 1'b0;
    cyc(1);
    expect_val("R6 ring irq", 1, 16'h0);

    // R7 event in the same cycle as the clearing read
    ring_in = 1'b1; reg_addr = 2'd2; reg_rd = 1'b1;
    cyc(1);
    reg_rd = 1'b0;
    expect_val("R7 event beats clear", 1, 16'h0);
    rd_chk(2'd2, "R8 ring set", {3'b0, 1'b1, 1'b0, gin});
    expect_val("R7 later clear", 1, 16'h1);

    // R3 pin 0 carrier clocks
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 9'h049 | 9'(s << 4));
      count_tog(0, 64, tg);
      meas = 16'(tg);
      expect_val($sformatf("R3 pin0 divide sel %0d", s), 5, 16'(64 / (CH << s)));
    end

    // R4 pin 3 carries F0, pin 0 back to static
    wr(2'd2, 9'h089);
    count_tog(1, 64, tg);
    meas = 16'(tg);
    expect_val("R4 pin3 F0 toggles", 5, 16'(64 / CH));
    meas = {15'b0, gpio_out[0]};
    expect_val("R3 pin0 static again", 5, 16'h1);
    wr(2'd2, 9'h009);

    // R9/R10 mode from register
    wr(2'd3, 9'h001);
    cyc(2);
    chk_offhook("R10 reg");
    wr(2'd3, 9'h002);
    cyc(2);
    chk_cid("R10 reg");
    wr(2'd3, 9'h003);
    cyc(2);
    chk_idle("R10 spare");
    wr(2'd3, 9'h000);
    cyc(2);
    chk_idle("R10 onhook");

    // R9 mode from pins
    gin[2] = 1'b1; gin[1] = 1'b0; gpio_in = gin;
    hw_mode = 1'b1;
    cyc(5);
    chk_offhook("R9 pin");
    gin[2] = 1'b0; gin[1] = 1'b1; gpio_in = gin;
    cyc(5);
    chk_cid("R9 pin");
    hw_mode = 1'b0;
    cyc(2);
    chk_idle("R9 back to reg");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule